// File: doc/BRIEF.md
# SPI Control Register Access Target

This block sits on the device side of an SPI link and services register commands from the host. The bit-level shifter in front of it hands over one 32-bit word at a time while chip select is active. The block hands back one 32-bit word for every word it receives. Each command opens with a header word. The header says whether to read or write, which register map and address to start at, how many consecutive registers to touch, and whether the address should step after each register. A parity bit protects the header.

Register accesses go out on a simple synchronous port. A read strobe returns data on the following cycle. A combinational "implemented" flag tells the block whether the current select/address pair exists. A write command echoes its header and data back to the host, so the host can see which write was corrupted on the wire. A read command returns the register contents and discards whatever the host shifts in. The host sees each reply one word after the word that caused it.

Top module: `spi_ctl_target`

## Requirements
- R1: After reset, `tx_valid` is 0, `tx_word` is 0, `hdr_err` is 0 and neither register strobe is asserted.
- R2: Every word accepted while `cs_active` is 1 produces exactly one output word on the next cycle. That word is the reply to the word accepted before it. The first output word of a frame is 0. No output word appears without an accepted input word.
- R3: The header layout is: bit 31 = 0 for a control command, bit 30 = write (1) or read (0), bit 29 = hold address (1) or step it, bits 28:25 = map select, bits 24:9 = start address, bits 8:2 = register count minus one, bit 1 = spare, bit 0 = parity. Odd parity over all 32 bits marks a good header.
- R4: A write header with count N is followed by N data words and one trailing word. The data words are written to the register port in order. The replies are the header, then each data word. The trailing word is not written, and its reply is 0.
- R5: A read header with count N is followed by N+1 host words whose contents are ignored. The replies are the header, then the N register values in address order.
- R6: Unless the hold bit is set, the address steps by one after each register and wraps from 0xFFFF to 0x0000 within the same map. With the hold bit set, every access uses the start address.
- R7: A read of a register whose implemented flag is 0 returns 0, whatever the port's read data holds.
- R8: A write to a register whose implemented flag is 0 raises no write strobe and leaves every register unchanged.
- R9: A control header with bad parity performs no register access. It sets `hdr_err`, which stays set until reset. The rest of the frame replies 0.
- R10: A header with bit 31 set is not a control command. The rest of the frame is ignored: replies 0, no access, `hdr_err` unchanged.
- R11: Deasserting `cs_active` ends any command in progress. The first word of the next frame is decoded as a header. Several complete commands may follow one another inside one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_active | input | 1 | Chip select asserted (frame in progress) |
| rx_valid | input | 1 | A host word is present on `rx_word` this cycle |
| rx_word | input | 32 | Word received from the host |
| tx_valid | output | 1 | A reply word is present on `tx_word` |
| tx_word | output | 32 | Word to shift out to the host |
| hdr_err | output | 1 | Sticky header parity error flag |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_sel | output | 4 | Register map select for the access |
| reg_addr | output | 16 | Register address for the access |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, valid the cycle after `reg_rd` |
| reg_impl | input | 1 | Current `reg_sel`/`reg_addr` is an implemented register |

## Verification
A reply word becomes visible one edge after the input word that follows the word it answers. The bench predicts the full reply stream of each frame before sending it. It samples `tx_valid` and `tx_word` just after every edge and pairs each edge with the reply due there. Idle edges between words must show no output. Write and read strobes occur in the same cycle as the word that causes them, and read data is consumed one cycle later. Register effects are therefore judged by reading the registers back in a later frame through the same interface. The header error flag is due on the edge that takes the bad header. It is checked at each frame end.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 16;
    localparam int SEL_W  = 4;
    localparam int LEN_W  = 7;

    // header field positions
    localparam int POS_DNC   = WORD_W - 1;
    localparam int POS_WNR   = WORD_W - 2;
    localparam int POS_HOLD  = WORD_W - 3;
    localparam int SEL_LSB   = POS_HOLD - SEL_W;
    localparam int ADDR_LSB  = SEL_LSB - ADDR_W;
    localparam int LEN_LSB   = ADDR_LSB - LEN_W;

    typedef struct packed {
        logic              dnc;
        logic              wnr;
        logic              hold;
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              par_ok;
    } hdr_t;

    typedef enum logic [1:0] {
        ST_HDR,
        ST_BODY,
        ST_TAIL,
        ST_SKIP
    } seq_st_e;

endpackage

// File: rtl/spi_ctl_hdr_dec.sv
module spi_ctl_hdr_dec
    import spi_ctl_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr
);

    always_comb begin
        hdr.dnc    = word[POS_DNC];
        hdr.wnr    = word[POS_WNR];
        hdr.hold   = word[POS_HOLD];
        hdr.sel    = word[SEL_LSB +: SEL_W];
        hdr.addr   = word[ADDR_LSB +: ADDR_W];
        hdr.len    = word[LEN_LSB +: LEN_W];
        // odd number of ones across the whole word marks a good header
        hdr.par_ok = ^word;
    end

endmodule

// File: rtl/spi_ctl_addr_step.sv
module spi_ctl_addr_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              hold,
    output logic [ADDR_W-1:0] next
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_comb begin
        next = hold ? base : base + ONE;
    end

endmodule

// File: rtl/spi_ctl_rd_cap.sv
module spi_ctl_rd_cap
    import spi_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic              rd_impl,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] rd_now
);

    typedef struct packed {
        logic              pend;
        logic              impl;
        logic [WORD_W-1:0] hold;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [WORD_W-1:0] masked;

    always_comb begin
        masked = cap_q.impl ? rdata : '0;
        rd_now = cap_q.pend ? masked : cap_q.hold;

        cap_d      = cap_q;
        cap_d.pend = rd_issue;
        cap_d.impl = rd_issue & rd_impl;
        if (cap_q.pend) begin
            cap_d.hold = masked;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

endmodule

// File: rtl/spi_ctl_seq.sv
module spi_ctl_seq
    import spi_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    input  hdr_t              hdr,
    input  logic [ADDR_W-1:0] hdr_addr_next,
    input  logic [ADDR_W-1:0] cur_addr_next,
    input  logic [WORD_W-1:0] rd_now,
    input  logic              reg_impl,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_hold,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_word,
    output logic              hdr_err,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [SEL_W-1:0]  reg_sel,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata
);

    localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        seq_st_e           st;
        logic              wnr;
        logic              hold;
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
        logic [WORD_W-1:0] pend;
        logic [WORD_W-1:0] txw;
        logic              txv;
        logic              herr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.txv = 1'b0;
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        reg_sel   = seq_q.sel;
        reg_addr  = seq_q.addr;
        reg_wdata = rx_word;

        if (!cs_active) begin
            seq_d.st   = ST_HDR;
            seq_d.pend = '0;
        end else if (rx_valid) begin
            seq_d.txv = 1'b1;
            seq_d.txw = seq_q.pend;
            unique case (seq_q.st)
                ST_HDR: begin
                    seq_d.pend = '0;
                    if (hdr.dnc) begin
                        seq_d.st = ST_SKIP;
                    end else if (!hdr.par_ok) begin
                        seq_d.st   = ST_SKIP;
                        seq_d.herr = 1'b1;
                    end else begin
                        seq_d.st   = ST_BODY;
                        seq_d.pend = rx_word;
                        seq_d.wnr  = hdr.wnr;
                        seq_d.hold = hdr.hold;
                        seq_d.sel  = hdr.sel;
                        seq_d.left = hdr.len;
                        if (hdr.wnr) begin
                            seq_d.addr = hdr.addr;
                        end else begin
                            // prefetch the first register
                            reg_rd     = 1'b1;
                            reg_sel    = hdr.sel;
                            reg_addr   = hdr.addr;
                            seq_d.addr = hdr_addr_next;
                        end
                    end
                end
                ST_BODY: begin
                    if (seq_q.wnr) begin
                        reg_wr     = reg_impl;
                        seq_d.pend = rx_word;
                        seq_d.addr = cur_addr_next;
                    end else begin
                        seq_d.pend = rd_now;
                        if (seq_q.left != '0) begin
                            reg_rd     = 1'b1;
                            seq_d.addr = cur_addr_next;
                        end
                    end
                    if (seq_q.left == '0) begin
                        seq_d.st = ST_TAIL;
                    end else begin
                        seq_d.left = seq_q.left - LEN_ONE;
                    end
                end
                ST_TAIL: begin
                    seq_d.pend = '0;
                    seq_d.st   = ST_HDR;
                end
                default: begin
                    seq_d.pend = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_HDR;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cur_addr = seq_q.addr;
    assign cur_hold = seq_q.hold;
    assign tx_valid = seq_q.txv;
    assign tx_word  = seq_q.txw;
    assign hdr_err  = seq_q.herr;

endmodule

// File: rtl/spi_ctl_target.sv
module spi_ctl_target
    import spi_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_word,
    output logic              hdr_err,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [SEL_W-1:0]  reg_sel,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata,
    input  logic              reg_impl
);

    hdr_t              hdr;
    logic [ADDR_W-1:0] hdr_addr_next;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_hold;
    logic [ADDR_W-1:0] cur_addr_next;
    logic [WORD_W-1:0] rd_now;

    spi_ctl_hdr_dec u_dec (
        .word (rx_word),
        .hdr  (hdr)
    );

    spi_ctl_addr_step #(.ADDR_W(ADDR_W)) u_step_hdr (
        .base (hdr.addr),
        .hold (hdr.hold),
        .next (hdr_addr_next)
    );

    spi_ctl_addr_step #(.ADDR_W(ADDR_W)) u_step_cur (
        .base (cur_addr),
        .hold (cur_hold),
        .next (cur_addr_next)
    );

    spi_ctl_rd_cap u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (reg_rd),
        .rd_impl  (reg_impl),
        .rdata    (reg_rdata),
        .rd_now   (rd_now)
    );

    spi_ctl_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_active     (cs_active),
        .rx_valid      (rx_valid),
        .rx_word       (rx_word),
        .hdr           (hdr),
        .hdr_addr_next (hdr_addr_next),
        .cur_addr_next (cur_addr_next),
        .rd_now        (rd_now),
        .reg_impl      (reg_impl),
        .cur_addr      (cur_addr),
        .cur_hold      (cur_hold),
        .tx_valid      (tx_valid),
        .tx_word       (tx_word),
        .hdr_err       (hdr_err),
        .reg_rd        (reg_rd),
        .reg_wr        (reg_wr),
        .reg_sel       (reg_sel),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata)
    );

endmodule

// File: rtl/spi_ctl_target_chk.sv
module spi_ctl_target_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_active,
    input logic rx_valid,
    input logic tx_valid,
    input logic hdr_err,
    input logic reg_rd,
    input logic reg_wr,
    input logic reg_impl
);

    // R2
    word_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active && rx_valid) |=> tx_valid);

    // R2
    no_spurious_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_active && rx_valid) |=> !tx_valid);

    // R8
    impl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> reg_impl);

    // R9
    herr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |=> hdr_err);

    // R9
    herr_noaccess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_err) |-> $past(!reg_rd && !reg_wr));

    // R5
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |-> (cs_active && rx_valid));

    // R4
    access_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

endmodule

bind spi_ctl_target spi_ctl_target_chk u_chk (.*);

// File: tb/spi_ctl_target_bench.sv
module spi_ctl_target_bench;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        cs_active;
    logic        rx_valid;
    logic [31:0] rx_word;
    logic        tx_valid;
    logic [31:0] tx_word;
    logic        hdr_err;
    logic        reg_rd;
    logic        reg_wr;
    logic [3:0]  reg_sel;
    logic [15:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        reg_impl;

    spi_ctl_target u_spi_ctl_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .tx_valid  (tx_valid),
        .tx_word   (tx_word),
        .hdr_err   (hdr_err),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_impl  (reg_impl)
    );

    // Implemented registers: map 1, addresses 0..5, 0xFFFE and 0xFFFF.
    function automatic int reg_index(input logic [3:0] s, input logic [15:0] a);
        if (s != 4'd1) return -1;
        if (a < 16'd6) return int'(a);
        if (a == 16'hFFFE) return 6;
        if (a == 16'hFFFF) return 7;
        return -1;
    endfunction

    logic [31:0] rf_mem [8];
    int          rd_cnt, wr_cnt, ghost_cnt;

    assign reg_impl = (reg_index(reg_sel, reg_addr) >= 0);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) rf_mem[i] <= '0;
            reg_rdata <= '0;
            rd_cnt    <= 0;
            wr_cnt    <= 0;
            ghost_cnt <= 0;
        end else begin
            if (reg_rd) begin
                rd_cnt    <= rd_cnt + 1;
                reg_rdata <= reg_impl ? rf_mem[reg_index(reg_sel, reg_addr)] : 32'hBAD0_0BAD;
            end
            if (reg_wr) begin
                wr_cnt <= wr_cnt + 1;
                if (reg_impl) rf_mem[reg_index(reg_sel, reg_addr)] <= reg_wdata;
                else ghost_cnt <= ghost_cnt + 1;
            end
        end
    end

    // reference state
    logic [31:0] ref_mem [8];
    bit          exp_herr;
    int          total, bad;
    bit          finished;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_hdr(input bit dnc, input bit wnr, input bit hold,
                                           input logic [3:0] sel, input logic [15:0] addr,
                                           input logic [6:0] len);
        logic [31:0] w;
        w    = {dnc, wnr, hold, sel, addr, len, 2'b00};
        w[0] = ~^w[31:1];
        return w;
    endfunction

    // Sends one frame, predicting every reply and checking it on its edge.
    task automatic run_frame(input logic [31:0] w[$], input int gap, input string tag);
        int          mst = 0;      // 0 header, 1 body, 2 tail, 3 skip
        bit          mw = 0, mhold = 0;
        logic [3:0]  msel = '0;
        logic [15:0] maddr = '0;
        int          mleft = 0;
        logic [31:0] prev = '0;
        logic [31:0] resp;
        int          ix;
        @(negedge clk);
        cs_active = 1'b1;
        foreach (w[k]) begin
            resp = '0;
            case (mst)
                0: begin
                    if (w[k][31]) mst = 3;
                    else if (^w[k] != 1'b1) begin mst = 3; exp_herr = 1; end
                    else begin
                        mw = w[k][30]; mhold = w[k][29]; msel = w[k][28:25];
                        maddr = w[k][24:9]; mleft = int'(w[k][8:2]);
                        resp = w[k]; mst = 1;
                    end
                end
                1: begin
                    ix = reg_index(msel, maddr);
                    if (mw) begin
                        resp = w[k];
                        if (ix >= 0) ref_mem[ix] = w[k];
                    end else begin
                        resp = (ix >= 0) ? ref_mem[ix] : 32'h0;
                    end
                    if (!mhold) maddr = maddr + 16'd1;
                    if (mleft == 0) mst = 2; else mleft--;
                end
                2: mst = 0;
                default: ;
            endcase
            rx_valid = 1'b1;
            rx_word  = w[k];
            @(posedge clk); #1;
            chk(tx_valid === 1'b1 && tx_word === prev, {tag, " R2 reply"}, tx_word, prev);
            prev = resp;
            @(negedge clk);
            rx_valid = 1'b0;
            rx_word  = '0;
            for (int g = 0; g < gap; g++) begin
                @(posedge clk); #1;
                chk(tx_valid === 1'b0, {tag, " R2 idle"}, {31'b0, tx_valid}, 32'h0);
                @(negedge clk);
            end
        end
        cs_active = 1'b0;
        @(posedge clk); #1;
        chk(tx_valid === 1'b0, {tag, " R11 end"}, {31'b0, tx_valid}, 32'h0);
        chk(hdr_err === exp_herr, {tag, " R9 flag"}, {31'b0, hdr_err}, {31'b0, exp_herr});
    endtask

    localparam logic [31:0] J = 32'h5A5A_A5A5;

    initial begin
        int rd0, wr0;
        total = 0; bad = 0; finished = 0; exp_herr = 0;
        for (int i = 0; i < 8; i++) ref_mem[i] = '0;
        rst_n = 1'b0; cs_active = 1'b0; rx_valid = 1'b0; rx_word = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1
        chk(tx_valid === 1'b0 && tx_word === 32'h0, "R1 tx reset", tx_word, 32'h0);
        chk(hdr_err === 1'b0, "R1 flag reset", {31'b0, hdr_err}, 32'h0);
        chk(!reg_rd && !reg_wr, "R1 strobes reset", {30'b0, reg_rd, reg_wr}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 R6: burst write of three registers
        run_frame('{mk_hdr(0,1,0,4'd1,16'd0,7'd2), 32'h1111_0001, 32'h2222_0002, 32'h3333_0003, J}, 1, "R4 write");
        // R5: read back with gaps and back-to-back
        run_frame('{mk_hdr(0,0,0,4'd1,16'd0,7'd2), J, 32'hFFFF_FFFF, J, 32'h0}, 2, "R5 read gap");
        run_frame('{mk_hdr(0,0,0,4'd1,16'd0,7'd2), J, J, J, J}, 0, "R5 read b2b");
        // R6: hold bit
        run_frame('{mk_hdr(0,1,1,4'd1,16'd3,7'd1), 32'hAAAA_0001, 32'hBBBB_0002, J}, 0, "R6 hold write");
        run_frame('{mk_hdr(0,0,0,4'd1,16'd3,7'd1), J, J, J}, 1, "R6 hold read");
        // R6: wrap
        run_frame('{mk_hdr(0,1,0,4'd1,16'hFFFF,7'd1), 32'hC0DE_FFFF, 32'hC0DE_0000, J}, 0, "R6 wrap write");
        run_frame('{mk_hdr(0,0,0,4'd1,16'hFFFE,7'd2), J, J, J, J}, 0, "R6 wrap read");
        // R7
        run_frame('{mk_hdr(0,0,0,4'd1,16'h0020,7'd1), J, J, J}, 1, "R7 unimpl addr");
        run_frame('{mk_hdr(0,0,0,4'd2,16'd0,7'd0), J, J}, 0, "R7 unimpl map");
        // R8
        run_frame('{mk_hdr(0,1,0,4'd2,16'd1,7'd0), 32'hDEAD_0001, J}, 0, "R8 unimpl write");
        run_frame('{mk_hdr(0,0,0,4'd1,16'd1,7'd0), J, J}, 0, "R8 readback");
        chk(ghost_cnt == 0, "R8 no strobe", ghost_cnt, 0);
        // R10
        rd0 = rd_cnt; wr0 = wr_cnt;
        run_frame('{mk_hdr(1,1,0,4'd1,16'd2,7'd0), 32'h7777_7777, J}, 0, "R10 data hdr");
        chk(rd_cnt == rd0 && wr_cnt == wr0, "R10 no access", rd_cnt + wr_cnt, rd0 + wr0);
        run_frame('{mk_hdr(0,0,0,4'd1,16'd2,7'd0), J, J}, 0, "R10 readback");
        // R11: frame cut short, then a fresh command
        run_frame('{mk_hdr(0,1,0,4'd1,16'd4,7'd3), 32'h4444_0004}, 0, "R11 cut");
        run_frame('{mk_hdr(0,0,0,4'd1,16'd4,7'd1), J, J, J}, 0, "R11 after cut");
        // R11: two commands in one frame
        run_frame('{mk_hdr(0,1,0,4'd1,16'd5,7'd0), 32'h5555_0005, J,
                    mk_hdr(0,0,0,4'd1,16'd5,7'd0), J, J}, 0, "R11 two cmds");
        // R3 R9: parity error
        rd0 = rd_cnt; wr0 = wr_cnt;
        run_frame('{mk_hdr(0,1,0,4'd1,16'd0,7'd0) ^ 32'h0000_0200, 32'h9999_9999, J}, 0, "R9 bad parity");
        chk(rd_cnt == rd0 && wr_cnt == wr0, "R9 no access", rd_cnt + wr_cnt, rd0 + wr0);
        run_frame('{mk_hdr(0,0,0,4'd1,16'd0,7'd1), J, J, J}, 0, "R9 sticky then R3 read");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule